// File: doc/BRIEF.md
# Double-Buffered LCD Frame Fetch Addresser

This block produces the stream of memory burst requests that an LCD controller uses to read a display frame from memory. It drives one request at a time toward a bus master, holding the address and burst length steady until the master acknowledges. It also exposes the current fetch position inside the frame and pulses an end-of-frame interrupt when a frame has been fully requested. It works with single-scan panels and with dual-scan panels, which have separate upper and lower half buffers.

Software programs two base addresses, the frame size and the burst length through a small register-write port. These writes land in shadow registers. They become active only after software writes an update strobe, and then only at the next frame boundary. This lets software fill a back buffer and swap it in without tearing. While fetching is disabled, a pending update takes effect at once, so the first frame can be set up before fetching is enabled.

Top module: `lcd_frame_addr`

## Requirements
- R1: After reset, req_o, eof_irq_o and upd_pending_o are 0 and both frame pointer outputs read 0.
- R2: While the enable bit (control bit 0) is 0 and no request is outstanding, req_o stays 0.
- R3: Register index 0 is the upper base, 1 the lower base, 2 the frame size in bytes, 3 the burst length in 32-bit words, and 4 the control word (bit 0 enable, bit 1 dual-scan, bit 2 update strobe). Writes to indices 0 to 3 and to the dual-scan bit go to shadow copies and never change the fetch sequence until they are committed.
- R4: Writing control bit 2 as 1 sets upd_pending_o. The shadow values are committed and the flag clears at the next end of frame. If enable is 0 and no request is outstanding, this happens within two cycles instead.
- R5: In single-scan mode, the bursts of a frame go to base, base+4L, base+8L and so on, with req_len_o = L. The frame ends after the burst at which the next offset reaches the frame size, and the next burst starts again at the active base.
- R6: Once raised, req_o stays high with req_addr_o and req_len_o unchanged until ack_i is sampled high.
- R7: In dual-scan mode, bursts alternate upper, lower, upper and so on at the same offset, starting with the upper panel. The offset advances only after each lower burst, and the frame ends only after the lower panel's final burst.
- R8: eof_irq_o is high for exactly one cycle, in the cycle after the acknowledge of a frame's final burst.
- R9: frm_ptr_up_o and frm_ptr_lo_o equal the active upper and lower base plus the offset of the next burst.
- R10: When enable is cleared, an outstanding request still completes, no further request follows, and the pointers return to the active bases. Re-enabling starts at the start of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Register index |
| cfg_wdata_i | input | DW | Register write data |
| upd_pending_o | output | 1 | Update strobe written, commit not yet done |
| req_o | output | 1 | Burst request |
| req_addr_o | output | AW | Burst start byte address |
| req_len_o | output | LW | Burst length in words |
| ack_i | input | 1 | Burst accepted by the bus master |
| frm_ptr_up_o | output | AW | Upper-panel fetch pointer |
| frm_ptr_lo_o | output | AW | Lower-panel fetch pointer |
| eof_irq_o | output | 1 | End-of-frame pulse |

## Verification
The bench swaps buffers in the middle of a run. A design that applied shadow writes without the strobe, or at once rather than at the boundary, would send a burst to the new base one frame too early. In dual-scan mode the bench stops the fetch just before the last lower burst. A design that raised end of frame after the upper half alone would show an extra interrupt there. The bench also clears enable in the middle of a frame and checks that the outstanding burst completes and that the pointers fall back to the base. A design that dropped the request or kept the offset would fail that check. It also changes the burst length and frame size in one commit, so a wrong stride or a wrong end point shows up in the address sequence.

// File: rtl/lfa_pkg.sv
package lfa_pkg;
  typedef enum logic [2:0] {
    REG_BASE_UP = 3'd0,
    REG_BASE_LO = 3'd1,
    REG_FSIZE   = 3'd2,
    REG_BURST   = 3'd3,
    REG_CTRL    = 3'd4
  } reg_idx_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_DUAL = 1;
  localparam int unsigned CTRL_UPD  = 2;
endpackage

// File: rtl/lfa_cfg_regs.sv
module lfa_cfg_regs
  import lfa_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 24,
  parameter int unsigned LW = 5,
  parameter int unsigned DEF_SIZE = 64,
  parameter int unsigned DEF_LEN  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  reg_idx_e      idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          commit_ok_i,
  output logic          en_o,
  output logic          pend_o,
  output logic [AW-1:0] base_up_o,
  output logic [AW-1:0] base_lo_o,
  output logic [SW-1:0] fsize_o,
  output logic [LW-1:0] blen_o,
  output logic          dual_o
);
  localparam logic [SW-1:0] RST_SIZE = SW'(DEF_SIZE);
  localparam logic [LW-1:0] RST_LEN  = LW'(DEF_LEN);

  logic [AW-1:0] sh_up_q, sh_lo_q, act_up_q, act_lo_q;
  logic [SW-1:0] sh_size_q, act_size_q;
  logic [LW-1:0] sh_len_q, act_len_q;
  logic          sh_dual_q, act_dual_q, en_q, pend_q;
  logic          upd_wr, commit;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign upd_wr = we_i && (idx_i == REG_CTRL) && wdata_i[CTRL_UPD];
  assign commit = pend_q && commit_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_up_q   <= '0;
      sh_lo_q   <= '0;
      sh_size_q <= RST_SIZE;
      sh_len_q  <= RST_LEN;
      sh_dual_q <= 1'b0;
      en_q      <= 1'b0;
    end else if (we_i) begin
      case (idx_i)
        REG_BASE_UP: sh_up_q   <= wdata_i[AW-1:0];
        REG_BASE_LO: sh_lo_q   <= wdata_i[AW-1:0];
        REG_FSIZE:   sh_size_q <= wdata_i[SW-1:0];
        REG_BURST:   sh_len_q  <= wdata_i[LW-1:0];
        REG_CTRL: begin
          en_q      <= wdata_i[CTRL_EN];
          sh_dual_q <= wdata_i[CTRL_DUAL];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_up_q   <= '0;
      act_lo_q   <= '0;
      act_size_q <= RST_SIZE;
      act_len_q  <= RST_LEN;
      act_dual_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      pend_q <= (pend_q && !commit) || upd_wr;
      if (commit) begin
        act_up_q   <= sh_up_q;
        act_lo_q   <= sh_lo_q;
        act_size_q <= sh_size_q;
        act_len_q  <= sh_len_q;
        act_dual_q <= sh_dual_q;
      end
    end
  end

  assign en_o      = en_q;
  assign pend_o    = pend_q;
  assign base_up_o = act_up_q;
  assign base_lo_o = act_lo_q;
  assign fsize_o   = act_size_q;
  assign blen_o    = act_len_q;
  assign dual_o    = act_dual_q;

  p_active_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(act_up_q) && $stable(act_lo_q) && $stable(act_size_q)
                && $stable(act_len_q) && $stable(act_dual_q));

  p_pend_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !upd_wr) |=> !pend_q);
endmodule

// File: rtl/lfa_fetch_seq.sv
module lfa_fetch_seq #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 24,
  parameter int unsigned LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dual_i,
  input  logic [AW-1:0] base_up_i,
  input  logic [AW-1:0] base_lo_i,
  input  logic [SW-1:0] fsize_i,
  input  logic [LW-1:0] blen_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] ptr_up_o,
  output logic [AW-1:0] ptr_lo_o,
  output logic          eof_o,
  output logic          commit_ok_o
);
  logic          req_q, sel_q, eof_q;
  logic [SW-1:0] off_q;
  logic [SW:0]   step, off_nxt;
  logic          hs, last, eof_evt;

  // burst length in words -> bytes
  assign step    = {{(SW-1-LW){1'b0}}, blen_i, 2'b00};
  assign off_nxt = {1'b0, off_q} + step;
  assign hs      = req_q && ack_i;
  assign last    = (off_nxt >= {1'b0, fsize_i}) && (!dual_i || sel_q);
  assign eof_evt = hs && en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      sel_q <= 1'b0;
      off_q <= '0;
      eof_q <= 1'b0;
    end else begin
      eof_q <= eof_evt;
      if (hs) begin
        if (!en_i) begin
          req_q <= 1'b0;
          sel_q <= 1'b0;
          off_q <= '0;
        end else if (dual_i && !sel_q) begin
          sel_q <= 1'b1;
        end else begin
          sel_q <= 1'b0;
          off_q <= last ? '0 : off_nxt[SW-1:0];
        end
      end else if (!req_q) begin
        req_q <= en_i;
        if (!en_i) begin
          sel_q <= 1'b0;
          off_q <= '0;
        end
      end
    end
  end

  assign ptr_up_o    = base_up_i + AW'(off_q);
  assign ptr_lo_o    = base_lo_i + AW'(off_q);
  assign addr_o      = sel_q ? ptr_lo_o : ptr_up_o;
  assign req_o       = req_q;
  assign eof_o       = eof_q;
  assign commit_ok_o = eof_evt || (!req_q && !en_i);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q && $stable(addr_o) && $stable(blen_i));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !req_q) |=> !req_q);

  p_eof_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |-> $past(hs));

  p_eof_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |-> (off_q == '0) && !sel_q);

  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !en_i) |=> !req_q && (off_q == '0));
endmodule

// File: rtl/lcd_frame_addr.sv
module lcd_frame_addr
  import lfa_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 24,
  parameter int unsigned LW = 5,
  parameter int unsigned DEF_SIZE = 64,
  parameter int unsigned DEF_LEN  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_idx_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic          upd_pending_o,
  output logic          req_o,
  output logic [AW-1:0] req_addr_o,
  output logic [LW-1:0] req_len_o,
  input  logic          ack_i,
  output logic [AW-1:0] frm_ptr_up_o,
  output logic [AW-1:0] frm_ptr_lo_o,
  output logic          eof_irq_o
);
  logic          en, dual, commit_ok;
  logic [AW-1:0] base_up, base_lo;
  logic [SW-1:0] fsize;
  logic [LW-1:0] blen;

  lfa_cfg_regs #(
    .DW(DW), .AW(AW), .SW(SW), .LW(LW), .DEF_SIZE(DEF_SIZE), .DEF_LEN(DEF_LEN)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .idx_i      (reg_idx_e'(cfg_idx_i)),
    .wdata_i    (cfg_wdata_i),
    .commit_ok_i(commit_ok),
    .en_o       (en),
    .pend_o     (upd_pending_o),
    .base_up_o  (base_up),
    .base_lo_o  (base_lo),
    .fsize_o    (fsize),
    .blen_o     (blen),
    .dual_o     (dual)
  );

  lfa_fetch_seq #(.AW(AW), .SW(SW), .LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .dual_i     (dual),
    .base_up_i  (base_up),
    .base_lo_i  (base_lo),
    .fsize_i    (fsize),
    .blen_i     (blen),
    .ack_i      (ack_i),
    .req_o      (req_o),
    .addr_o     (req_addr_o),
    .ptr_up_o   (frm_ptr_up_o),
    .ptr_lo_o   (frm_ptr_lo_o),
    .eof_o      (eof_irq_o),
    .commit_ok_o(commit_ok)
  );

  assign req_len_o = blen;
endmodule

// File: tb/tb_lcd_frame_addr.sv
module tb_lcd_frame_addr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        upd_pending_o, req_o, eof_irq_o;
  logic [31:0] req_addr_o, frm_ptr_up_o, frm_ptr_lo_o;
  logic [4:0]  req_len_o;
  logic        ack_i = 1'b0;

  typedef struct packed { logic [31:0] addr; logic [4:0] len; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, eof_cnt = 0, gap = 0;

  always #10 clk_i = ~clk_i;

  lcd_frame_addr dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] a, input logic [4:0] l);
    item_t it;
    it.addr = a; it.len = l;
    exp_q.push_back(it);
  endtask

  task automatic push_run(input logic [31:0] a, input int n, input logic [4:0] l);
    for (int i = 0; i < n; i++) push(a + 32'(i) * 32'(l) * 4, l);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(negedge clk_i); t++; end
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL drain timeout actual=%0d expected=0", exp_q.size());
    end
    repeat (3) @(negedge clk_i);
  endtask

  // monitor: acks with gaps, pops and compares each accepted burst (R5, R7)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (eof_irq_o) eof_cnt++;
      gap = (gap == 2) ? 0 : gap + 1;
      if (req_o && exp_q.size() != 0 && gap != 0) begin
        item_t e;
        e = exp_q.pop_front();
        chk("R5/R7 burst addr", req_addr_o, e.addr);
        chk("R5 burst len", 32'(req_len_o), 32'(e.len));
        ack_i = 1'b1;
      end else begin
        ack_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 req", 32'(req_o), 0);
    chk("R1 eof", 32'(eof_irq_o), 0);
    chk("R1 pending", 32'(upd_pending_o), 0);
    chk("R1 ptr up", frm_ptr_up_o, 0);
    chk("R1 ptr lo", frm_ptr_lo_o, 0);

    // R3 shadow writes with no strobe are not used; R2 no request while disabled
    wr(0, 32'h1000); wr(2, 64); wr(3, 4);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk("R2 idle req", 32'(req_o), 0);
    end
    chk("R3 ptr before strobe", frm_ptr_up_o, 0);

    // R4 idle commit
    wr(4, 32'h4);
    repeat (3) @(negedge clk_i);
    chk("R4 pending cleared idle", 32'(upd_pending_o), 0);
    chk("R9 ptr at base", frm_ptr_up_o, 32'h1000);

    // R5 single-scan frame
    push_run(32'h1000, 4, 4);
    wr(4, 32'h1);
    drain();
    chk("R8 one eof", 32'(eof_cnt), 1);
    chk("R5 ptr reload", frm_ptr_up_o, 32'h1000);

    // R9 mid-frame pointer
    push_run(32'h1000, 2, 4);
    drain();
    chk("R9 mid ptr", frm_ptr_up_o, 32'h1020);
    chk("R8 no eof mid", 32'(eof_cnt), 1);

    // R3 shadow base without strobe keeps old buffer
    wr(0, 32'h2000);
    push_run(32'h1020, 2, 4);
    push_run(32'h1000, 4, 4);
    drain();
    chk("R8 eof count", 32'(eof_cnt), 3);
    chk("R3 old base kept", frm_ptr_up_o, 32'h1000);

    // R4 strobe while running: commit at next frame boundary
    wr(4, 32'h5);
    @(negedge clk_i);
    chk("R4 pending set", 32'(upd_pending_o), 1);
    push_run(32'h1000, 4, 4);
    push_run(32'h2000, 4, 4);
    drain();
    chk("R4 pending clear", 32'(upd_pending_o), 0);
    chk("R8 eof count swap", 32'(eof_cnt), 5);
    chk("R4 new base", frm_ptr_up_o, 32'h2000);

    // R5 burst length and frame size change together
    wr(3, 8); wr(2, 96); wr(4, 32'h5);
    push_run(32'h2000, 4, 4);
    push_run(32'h2000, 3, 8);
    drain();
    chk("R8 eof count len", 32'(eof_cnt), 7);

    // R10 disable mid-frame
    push(32'h2000, 8);
    drain();
    wr(4, 32'h0);
    push(32'h2020, 8);
    drain();
    repeat (3) @(negedge clk_i);
    chk("R10 stopped", 32'(req_o), 0);
    chk("R10 ptr back to base", frm_ptr_up_o, 32'h2000);
    chk("R10 no eof", 32'(eof_cnt), 7);

    // R7 dual-scan
    wr(0, 32'h4000); wr(1, 32'h8000); wr(2, 32); wr(3, 2); wr(4, 32'h6);
    repeat (3) @(negedge clk_i);
    chk("R4 dual commit idle", 32'(upd_pending_o), 0);
    chk("R9 lower ptr", frm_ptr_lo_o, 32'h8000);
    for (int i = 0; i < 4; i++) begin
      push(32'h4000 + 32'(i * 8), 2);
      if (i < 3) push(32'h8000 + 32'(i * 8), 2);
    end
    wr(4, 32'h3);
    drain();
    chk("R7 no eof after upper only", 32'(eof_cnt), 7);
    chk("R9 lower ptr mid", frm_ptr_lo_o, 32'h8018);
    push(32'h8018, 2);
    for (int i = 0; i < 4; i++) begin
      push(32'h4000 + 32'(i * 8), 2);
      push(32'h8000 + 32'(i * 8), 2);
    end
    drain();
    chk("R7 dual eof count", 32'(eof_cnt), 9);

    // R10 stop in dual mode, re-enable restarts at frame start
    wr(4, 32'h2);
    push(32'h4000, 2);
    drain();
    chk("R10 dual stopped", 32'(req_o), 0);
    push(32'h4000, 2);
    push(32'h8000, 2);
    wr(4, 32'h3);
    drain();
    chk("R10 restart ptr", frm_ptr_up_o, 32'h4008);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule